// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides its clock by a programmable integer N = B·P + A and emits a single-cycle pulse once every N cycles. It is meant to sit in front of a phase comparator, which needs exactly one event per division period. Inside, a prescaler counter divides by either P or P+1. A swallow counter holds the prescaler at P+1 for the first A prescaler cycles of each period. A main counter ends the period after B prescaler cycles. All three counters run in the one clock domain.

The base modulus P is chosen from four values by a two-bit select. New settings arrive with a one-cycle load strobe and are held as pending. They become active only when the next output period begins, so a period that is already running is never cut short or stretched. An illegal setting is refused and raises an error flag. The divider then keeps its current and pending settings.

Top module: `pulse_swallow_div`

## Requirements
- R1: `div_pulse` rises once every B·P + A clock cycles, where P = 8 << `psel` (select 0, 1, 2, 3 gives P of 8, 16, 32, 64 and the alternate modulus P+1).
- R2: Within a period, the first A prescaler cycles last P+1 clocks and the remaining B−A last P. So A = 0 gives a period of B·P, and A = B gives a period of B·(P+1).
- R3: `div_pulse` is high for exactly one clock per period.
- R4: A legal load sampled in any cycle except the last cycle of a period takes effect from the next period. A load sampled in the last cycle of a period takes effect one period later. The running period always keeps its setting.
- R5: When several legal loads arrive before a period boundary, the last one is the one applied.
- R6: A load is illegal if A ≥ P, if B < A, or if B = 0. An illegal load is rejected, `cfg_err` is high in the cycle after it, and the division ratio does not change.
- R7: `cfg_err` stays high until a legal load (it is low in the cycle after that load) or until reset.
- R8: A rejected load does not discard a legal setting that is already pending.
- R9: A synchronous reset forces `div_pulse` and `cfg_err` low, clears all counters and restores the default setting (P = 8, A = 0, B = 4, so N = 32). The first cycle with reset low is a restart cycle, so the first pulse comes N+1 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that offers `psel`, `a_in`, `b_in` as the next setting |
| psel | input | 2 | Modulus select: P = 8 << psel |
| a_in | input | A_W | Swallow count A |
| b_in | input | B_W | Main count B |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |
| cfg_err | output | 1 | Set by a rejected load; cleared by a legal load or by reset |

## Verification
The hardest case to reach from the ports is a load that lands in the final cycle of a period. There the boundary transfer and the capture of the new setting happen on the same edge. The stimulus syncs to an observed pulse, counts exactly N edges and raises the strobe in that terminal cycle. It then expects one more period at the old ratio before the new one. The swallow ordering cannot be seen directly at the ports, so settings are chosen whose periods differ only when the P+1 phase is counted correctly: A = 0, A = B, and A = P−1.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
    localparam int PSEL_W = 2;
    localparam int MOD_W  = 7;

    function automatic logic [MOD_W-1:0] base_mod(input logic [PSEL_W-1:0] sel);
        return MOD_W'(8) << sel;
    endfunction
endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
    import swdiv_pkg::*;
#(
    parameter int A_W      = 6,
    parameter int B_W      = 12,
    parameter int RST_PSEL = 0,
    parameter int RST_A    = 0,
    parameter int RST_B    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PSEL_W-1:0] psel,
    input  logic [A_W-1:0]    a_in,
    input  logic [B_W-1:0]    b_in,
    input  logic              boundary,
    output logic [PSEL_W-1:0] act_psel,
    output logic [PSEL_W-1:0] nxt_psel,
    output logic [A_W-1:0]    nxt_a,
    output logic [B_W-1:0]    nxt_b,
    output logic              cfg_err
);
    localparam int AB_W = (A_W > B_W) ? A_W : B_W;
    localparam int CW   = (AB_W > MOD_W) ? AB_W : MOD_W;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [A_W-1:0]    a;
        logic [B_W-1:0]    b;
    } set_t;

    typedef struct packed {
        set_t act;
        set_t pend;
        logic pend_v;
        logic err;
    } cfg_t;

    localparam set_t RST_SET = {PSEL_W'(RST_PSEL), A_W'(RST_A), B_W'(RST_B)};

    cfg_t s_d, s_q;
    set_t req, nxt;
    logic legal;

    always_comb begin
        req   = {psel, a_in, b_in};
        legal = (b_in != '0)
             && (CW'(a_in) <= CW'(b_in))
             && (CW'(a_in) < CW'(base_mod(psel)));
        nxt   = s_q.pend_v ? s_q.pend : s_q.act;
        s_d   = s_q;
        if (boundary) begin
            s_d.act    = nxt;
            s_d.pend_v = 1'b0;
        end
        if (load) begin
            if (legal) begin
                s_d.pend   = req;
                s_d.pend_v = 1'b1;
                s_d.err    = 1'b0;
            end else begin
                s_d.err    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.act    <= RST_SET;
            s_q.pend   <= '0;
            s_q.pend_v <= 1'b0;
            s_q.err    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_psel = s_q.act.psel;
    assign nxt_psel = nxt.psel;
    assign nxt_a    = nxt.a;
    assign nxt_b    = nxt.b;
    assign cfg_err  = s_q.err;

    // R6: a load with B below A must raise the flag
    p_ratio_flag_r6: assert property (@(posedge clk) disable iff (rst)
        load && (CW'(b_in) < CW'(a_in)) |=> cfg_err);

    // R6: a load with B of zero must raise the flag
    p_zero_main_flag_r6: assert property (@(posedge clk) disable iff (rst)
        load && (b_in == '0) |=> cfg_err);

    // R6: the running setting is always a legal one
    p_active_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (s_q.act.b != '0) && (CW'(s_q.act.a) <= CW'(s_q.act.b))
        && (CW'(s_q.act.a) < CW'(base_mod(s_q.act.psel))));

    // R4: the running setting changes only at a period boundary
    p_hold_mid_period_r4: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(s_q.act));
endmodule

// File: rtl/swdiv_seq.sv
module swdiv_seq
    import swdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] act_psel,
    input  logic [PSEL_W-1:0] nxt_psel,
    input  logic [A_W-1:0]    nxt_a,
    input  logic [B_W-1:0]    nxt_b,
    output logic              boundary,
    output logic              div_pulse
);
    localparam int AB_W = (A_W > B_W) ? A_W : B_W;

    typedef struct packed {
        logic [MOD_W-1:0] pre;
        logic [A_W-1:0]   swl;
        logic [B_W-1:0]   main;
    } seq_t;

    seq_t s_d, s_q;
    logic             end_pc;
    logic [MOD_W-1:0] p_new, p_act;
    logic [A_W-1:0]   swl_n;

    always_comb begin
        s_d       = s_q;
        end_pc    = (s_q.pre == '0);
        boundary  = end_pc && (s_q.main <= B_W'(1));
        div_pulse = end_pc && (s_q.main == B_W'(1));
        p_new     = base_mod(nxt_psel);
        p_act     = base_mod(act_psel);
        swl_n     = (s_q.swl != '0) ? s_q.swl - A_W'(1) : '0;
        if (boundary) begin
            s_d.swl  = nxt_a;
            s_d.main = nxt_b;
            s_d.pre  = (nxt_a != '0) ? p_new : p_new - MOD_W'(1);
        end else if (end_pc) begin
            s_d.main = s_q.main - B_W'(1);
            s_d.swl  = swl_n;
            s_d.pre  = (swl_n != '0) ? p_act : p_act - MOD_W'(1);
        end else begin
            s_d.pre  = s_q.pre - MOD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: the output pulse never lasts two cycles
    p_one_cycle_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R1: the prescaler count never exceeds the alternate modulus minus one
    p_pre_bound_r1: assert property (@(posedge clk) disable iff (rst)
        s_q.pre <= base_mod(act_psel));

    // R2: the swallow phase never outlasts the main count
    p_swallow_order_r2: assert property (@(posedge clk) disable iff (rst)
        AB_W'(s_q.swl) <= AB_W'(s_q.main));

    // R9: the cycle after reset is a restart cycle with no pulse
    p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !div_pulse);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import swdiv_pkg::*;
#(
    parameter int A_W      = 6,
    parameter int B_W      = 12,
    parameter int RST_PSEL = 0,
    parameter int RST_A    = 0,
    parameter int RST_B    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PSEL_W-1:0] psel,
    input  logic [A_W-1:0]    a_in,
    input  logic [B_W-1:0]    b_in,
    output logic              div_pulse,
    output logic              cfg_err
);
    logic [PSEL_W-1:0] act_psel, nxt_psel;
    logic [A_W-1:0]    nxt_a;
    logic [B_W-1:0]    nxt_b;
    logic              boundary;

    swdiv_cfg #(
        .A_W(A_W), .B_W(B_W),
        .RST_PSEL(RST_PSEL), .RST_A(RST_A), .RST_B(RST_B)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(load),
        .psel(psel), .a_in(a_in), .b_in(b_in),
        .boundary(boundary),
        .act_psel(act_psel), .nxt_psel(nxt_psel),
        .nxt_a(nxt_a), .nxt_b(nxt_b),
        .cfg_err(cfg_err)
    );

    swdiv_seq #(
        .A_W(A_W), .B_W(B_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .act_psel(act_psel), .nxt_psel(nxt_psel),
        .nxt_a(nxt_a), .nxt_b(nxt_b),
        .boundary(boundary), .div_pulse(div_pulse)
    );
endmodule

// File: tb/sim_pulse_swallow_div.sv
`timescale 1ns/1ps
module sim_pulse_swallow_div;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [1:0]  psel = '0;
    logic [5:0]  a_in = '0;
    logic [11:0] b_in = '0;
    logic        div_pulse, cfg_err;

    int    exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cur_n = 32;
    int    mon_cnt = 0;
    bit    prev_p = 1'b0;
    bit    done = 1'b0;
    event  pulse_ev;

    always #2.5 clk = ~clk;

    pulse_swallow_div u0 (
        .clk(clk), .rst(rst), .load(load), .psel(psel),
        .a_in(a_in), .b_in(b_in), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: measure each period and compare against the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            mon_cnt = 0;
            prev_p  = 1'b0;
        end else begin
            mon_cnt++;
            if (prev_p) check("R3 pulse width", int'(div_pulse), 0);
            if (div_pulse) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected pulse", mon_cnt, 0);
                end else begin
                    check(tag_q.pop_front(), mon_cnt, exp_q.pop_front());
                end
                mon_cnt = 0;
                -> pulse_ev;
            end
            prev_p = div_pulse;
        end
    end

    task automatic push(input string tag, input int n);
        exp_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    task automatic wait_period(input string tag);
        @(pulse_ev);
        push(tag, cur_n);
    endtask

    task automatic drive_load(input int ps, input int a, input int b);
        @(posedge clk); #1;
        load = 1'b1; psel = 2'(ps); a_in = 6'(a); b_in = 12'(b);
        @(posedge clk); #1;
        load = 1'b0;
    endtask

    task automatic mid_load(input string tag, input int ps, input int a, input int b,
                            input bit legal);
        wait_period(tag);
        drive_load(ps, a, b);
        check({tag, " error flag"}, int'(cfg_err), legal ? 0 : 1);
        if (legal) cur_n = b * (8 << ps) + a;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 pulse in reset", int'(div_pulse), 0);
        check("R9 error in reset", int'(cfg_err), 0);
        exp_q.delete();
        tag_q.delete();
        cur_n = 32;
        push("R9 first period after reset", cur_n + 1);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        wait_period("R9 default ratio");
        mid_load("R1 8/9 A3 B5", 0, 3, 5, 1'b1);
        wait_period("R1 N=43");
        mid_load("R1 16/17 A=P-1", 1, 15, 20, 1'b1);
        wait_period("R1 N=335");
        mid_load("R2 A equals B", 0, 7, 7, 1'b1);
        wait_period("R2 N=63 all P+1");
        mid_load("R2 A zero", 2, 0, 2, 1'b1);
        wait_period("R2 N=64");
        mid_load("R1 64/65", 3, 63, 63, 1'b1);
        wait_period("R1 N=4095");
        mid_load("R1 minimum", 0, 0, 1, 1'b1);
        wait_period("R3 N=8");
        wait_period("R3 N=8 again");
        // R5: two loads in one period, last one wins
        wait_period("R5 old ratio");
        drive_load(1, 1, 1);
        drive_load(0, 2, 3);
        cur_n = 26;
        wait_period("R5 last load applied");
        // R6: three kinds of illegal load
        mid_load("R6 A not below P", 0, 8, 9, 1'b0);
        wait_period("R6 ratio kept");
        mid_load("R6 B below A", 1, 5, 3, 1'b0);
        mid_load("R6 B zero", 0, 0, 0, 1'b0);
        wait_period("R6 ratio kept again");
        check("R7 error held", int'(cfg_err), 1);
        mid_load("R7 legal load clears", 0, 1, 2, 1'b1);
        wait_period("R7 N=17");
        // R8: rejected load keeps pending legal setting
        wait_period("R8 old ratio");
        drive_load(0, 4, 6);
        drive_load(0, 9, 9);
        check("R8 error flag", int'(cfg_err), 1);
        cur_n = 52;
        wait_period("R8 pending applied N=52");
        // R4: load in the terminal cycle of a period
        wait_period("R4 period with terminal load");
        repeat (cur_n) @(posedge clk);
        #1;
        load = 1'b1; psel = 2'd1; a_in = 6'd2; b_in = 12'd3;
        @(posedge clk); #1;
        load = 1'b0;
        push("R4 one more old period", cur_n);
        cur_n = 50;
        wait_period("R4 terminal load applied N=50");
        // R9: reset mid-period with error flag set
        wait_period("R9 before reset");
        drive_load(0, 8, 8);
        repeat (5) @(posedge clk);
        do_reset();
        wait_period("R9 default after reset");
        @(pulse_ev);
        check("R1 scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check("R1 watchdog expired", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule